// File: doc/BRIEF.md
# Prescaler Reset Synchronization Controller

This block owns the reset lines of two clock prescalers. One prescaler runs from the CPU clock. The other can run from the CPU clock or from a separate, unrelated slow clock. Software uses one 8-bit control register to do two things. It can give a one-shot reset to either prescaler. It can also enter a hold mode, where every requested reset stays asserted, so that all timers stay frozen while they are configured. Leaving hold mode releases the held resets on one CPU clock edge, so the timers restart together.

When the second prescaler runs from the slow clock, its reset request crosses into that domain through a synchronizer. A synchronized acknowledge comes back to the CPU domain, and the request bit stays set until that acknowledge arrives. Software can therefore poll the bit to learn when the reset has really been applied. The prescalers are plain free-running divide counters. They are exposed only so that the behaviour of the resets can be observed.

Top module: `psr_sync_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x00, and `sync_psr_rst` and `async_psr_rst` are low.
- R2: Register layout:
  - bit 7 is the hold-mode bit;
  - bit 1 is the slow-prescaler reset request;
  - bit 0 is the fast-prescaler reset request;
  - bits 6..2 always read 0, and writing ones to them changes nothing.
- R3: With hold mode off, writing bit 0 as 1 makes bit 0 read 1 (and `sync_psr_rst` high) in the cycle after the write. Bit 0 reads 0 one cycle later.
- R4: With hold mode off and `async_mode` low, writing bit 1 as 1 makes bit 1 read 1 in the cycle after the write and 0 one cycle later.
- R5: While bit 7 is 1, request bits that have been set stay 1. A write with bit 7 = 1 and a request bit = 0 does not clear that request bit.
- R6: While a request bit is held, the matching prescaler count stays at 0.
- R7: A write with bit 7 = 0 issued during hold mode clears bit 7 and bit 0 on that edge. It also clears bit 1 on that edge if `async_mode` is low or the slow-domain acknowledge has already arrived. Both prescalers then count up in lockstep from 0.
- R8: With `async_mode` high and hold mode off, a written bit 1 stays 1 for at least two CPU cycles. It clears only after the slow domain has confirmed the reset, which happens within 20 CPU cycles at the default clocks.
- R9: The hardware never clears bit 1 while bit 7 is 1, even after the acknowledge has arrived.
- R10: With `async_mode` high, `async_psr_rst` follows the request synchronized into the slow domain. While it is high, the slow prescaler count stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low reset, CPU domain |
| slow_clk | input | 1 | Slow clock for the second prescaler |
| slow_rst_n | input | 1 | Active-low reset, slow domain |
| async_mode | input | 1 | 1: second prescaler runs from `slow_clk` |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| sync_psr_rst | output | 1 | Reset applied to the fast prescaler |
| async_psr_rst | output | 1 | Reset applied to the second prescaler |
| sync_div_cnt | output | DIV_W | Fast prescaler count |
| async_div_cnt | output | DIV_W | Second prescaler count (selected by `async_mode`) |

## Verification
The register is exercised with several kinds of write:
- single-bit strobes with hold mode off, which separate one-cycle self-clearing from latching;
- writes to the unused bits, which show that nothing is stored there;
- hold-mode writes that carry zeros in the request bits, which tell write-one-to-set apart from plain overwrite;
- a release write, which shows whether both counters leave reset on the same edge.

In the asynchronous setting, a polled request shows whether the bit waits for the slow-domain round trip or clears at once. A held request with the acknowledge already present shows whether hold mode outranks the acknowledge.

// File: rtl/psr_pkg.sv
package psr_pkg;
   localparam int REG_W    = 8;
   localparam int MODE_POS = 7;
   localparam int AREQ_POS = 1;
   localparam int SREQ_POS = 0;

   typedef struct packed {
      logic mode;
      logic areq;
      logic sreq;
   } psr_state_t;
endpackage

// File: rtl/psr_sync_chain.sv
module psr_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("psr_sync_chain needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] flop_q;

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) flop_q[0] <= 1'b0;
               else        flop_q[0] <= d;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) flop_q[i] <= 1'b0;
               else        flop_q[i] <= flop_q[i-1];
            end
         end
      end
   endgenerate

   assign q = flop_q[STAGES-1];
endmodule

// File: rtl/psr_div_counter.sv
module psr_div_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   output logic [W-1:0] cnt
);
   generate
      if (W < 1) begin : g_bad_width
         $error("psr_div_counter width must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (hold) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/psr_ctrl_reg.sv
module psr_ctrl_reg
   import psr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             async_mode,
   input  logic             ack_c,
   output psr_state_t       st,
   output logic             req_lvl,
   output logic [REG_W-1:0] rd_data
);
   psr_state_t nxt;
   logic       stale, stale_nxt;
   logic       confirm;
   logic       new_set;

   // A fresh request waits for the acknowledge to drop and rise again.
   assign confirm = !async_mode || (ack_c && !stale);
   assign new_set = wr_en && wr_data[AREQ_POS] && !st.areq;

   always_comb begin
      nxt = st;
      if (wr_en) begin
         nxt.mode = wr_data[MODE_POS];
         nxt.sreq = wr_data[SREQ_POS] | (st.sreq & wr_data[MODE_POS]);
         if (wr_data[AREQ_POS])      nxt.areq = 1'b1;
         else if (wr_data[MODE_POS]) nxt.areq = st.areq;
         else                        nxt.areq = st.areq & !confirm;
      end else begin
         nxt.sreq = st.sreq & st.mode;
         nxt.areq = st.areq & (st.mode | !confirm);
      end
   end

   always_comb begin
      stale_nxt = stale;
      if (new_set)     stale_nxt = 1'b1;
      else if (!ack_c) stale_nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= '0;
         stale <= 1'b0;
      end else begin
         st    <= nxt;
         stale <= stale_nxt;
      end
   end

   assign req_lvl = st.areq & !stale;

   always_comb begin
      rd_data           = '0;
      rd_data[MODE_POS] = st.mode;
      rd_data[AREQ_POS] = st.areq;
      rd_data[SREQ_POS] = st.sreq;
   end
endmodule

// File: rtl/psr_sync_ctrl.sv
module psr_sync_ctrl
   import psr_pkg::*;
#(
   parameter int DIV_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_clk,
   input  logic             slow_rst_n,
   input  logic             async_mode,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             sync_psr_rst,
   output logic             async_psr_rst,
   output logic [DIV_W-1:0] sync_div_cnt,
   output logic [DIV_W-1:0] async_div_cnt
);
   generate
      if (REG_W <= MODE_POS) begin : g_bad_reg
         $error("register too narrow for the mode bit");
      end
   endgenerate

   psr_state_t       st;
   logic             req_lvl;
   logic             req_s;
   logic             ack_c;
   logic [DIV_W-1:0] fast_alt_cnt;
   logic [DIV_W-1:0] slow_cnt;

   psr_ctrl_reg u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .async_mode (async_mode),
      .ack_c      (ack_c),
      .st         (st),
      .req_lvl    (req_lvl),
      .rd_data    (rd_data)
   );

   psr_sync_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (slow_clk),
      .rst_n (slow_rst_n),
      .d     (req_lvl),
      .q     (req_s)
   );

   psr_sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_s),
      .q     (ack_c)
   );

   psr_div_counter #(.W(DIV_W)) u_fast_div (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (st.sreq),
      .cnt   (sync_div_cnt)
   );

   psr_div_counter #(.W(DIV_W)) u_alt_fast_div (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (st.areq),
      .cnt   (fast_alt_cnt)
   );

   psr_div_counter #(.W(DIV_W)) u_slow_div (
      .clk   (slow_clk),
      .rst_n (slow_rst_n),
      .hold  (req_s),
      .cnt   (slow_cnt)
   );

   assign sync_psr_rst  = st.sreq;
   assign async_psr_rst = async_mode ? req_s : st.areq;
   assign async_div_cnt = async_mode ? slow_cnt : fast_alt_cnt;
endmodule

// File: rtl/psr_sync_ctrl_chk.sv
module psr_sync_ctrl_chk #(
   parameter int DIV_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             slow_clk,
   input logic             slow_rst_n,
   input logic             async_mode,
   input logic             wr_en,
   input logic [7:0]       wr_data,
   input logic [7:0]       rd_data,
   input logic             sync_psr_rst,
   input logic             async_psr_rst,
   input logic [DIV_W-1:0] sync_div_cnt,
   input logic [DIV_W-1:0] async_div_cnt
);
   assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[6:2] == 5'd0);

   assert_strobe_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_data[7] && rd_data[0] && !wr_en) |=> !rd_data[0]);

   assert_sync_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[7] && rd_data[0] && !(wr_en && !wr_data[7])) |=> rd_data[0]);

   assert_fast_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_psr_rst |=> (sync_div_cnt == '0));

   assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[7] && wr_en && !wr_data[7] && !wr_data[0]) |=> (!rd_data[7] && !rd_data[0]));

   assert_async_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (async_mode && $rose(rd_data[1])) |=> (rd_data[1] || !async_mode));

   assert_async_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[7] && rd_data[1] && !(wr_en && !wr_data[7])) |=> rd_data[1]);

   assert_slow_frozen_R10: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
      (async_mode && async_psr_rst) |=> (async_div_cnt == '0 || !async_mode));
endmodule

bind psr_sync_ctrl psr_sync_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .slow_clk      (slow_clk),
   .slow_rst_n    (slow_rst_n),
   .async_mode    (async_mode),
   .wr_en         (wr_en),
   .wr_data       (wr_data),
   .rd_data       (rd_data),
   .sync_psr_rst  (sync_psr_rst),
   .async_psr_rst (async_psr_rst),
   .sync_div_cnt  (sync_div_cnt),
   .async_div_cnt (async_div_cnt)
);

// File: tb/sim_psr_sync_ctrl.sv
module sim_psr_sync_ctrl;
   localparam int CLK_PERIOD  = 10;
   localparam int SLOW_PERIOD = 34;
   localparam int DIV_W       = 4;
   localparam int NVEC        = 9;
   // {write data, value read after the write, value read one cycle later}
   localparam logic [23:0] VEC [0:NVEC-1] = '{
      24'h01_01_00,   // R3 fast strobe
      24'h02_02_00,   // R4 slow strobe, CPU clocked
      24'h7C_00_00,   // R2 unused bits
      24'h80_80_80,   // R5 enter hold
      24'h81_81_81,   // R5 hold fast request
      24'h82_83_83,   // R5 add slow request, keep fast
      24'h80_83_83,   // R5 zeros do not clear
      24'h00_00_00,   // R7 release
      24'h03_03_00    // R3 R4 both strobes
   };

   logic             clk = 1'b0;
   logic             slow_clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             slow_rst_n = 1'b0;
   logic             async_mode = 1'b0;
   logic             wr_en = 1'b0;
   logic [7:0]       wr_data = 8'h00;
   logic [7:0]       rd_data;
   logic             sync_psr_rst;
   logic             async_psr_rst;
   logic [DIV_W-1:0] sync_div_cnt;
   logic [DIV_W-1:0] async_div_cnt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2)  clk = ~clk;
   always #(SLOW_PERIOD/2) slow_clk = ~slow_clk;

   psr_sync_ctrl #(.DIV_W(DIV_W)) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .slow_clk      (slow_clk),
      .slow_rst_n    (slow_rst_n),
      .async_mode    (async_mode),
      .wr_en         (wr_en),
      .wr_data       (wr_data),
      .rd_data       (rd_data),
      .sync_psr_rst  (sync_psr_rst),
      .async_psr_rst (async_psr_rst),
      .sync_div_cnt  (sync_div_cnt),
      .async_div_cnt (async_div_cnt)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Drives one write; returns at the falling edge after the capturing edge.
   task automatic reg_write(input logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = 8'h00;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      int waited;
      idle(3);
      rst_n      = 1'b1;
      slow_rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rd_data", rd_data, 8'h00);
      chk("R1 sync_psr_rst", sync_psr_rst, 1'b0);
      chk("R1 async_psr_rst", async_psr_rst, 1'b0);

      for (int v = 0; v < NVEC; v++) begin
         reg_write(VEC[v][23:16]);
         chk($sformatf("R2-vector %0d after write", v), rd_data, VEC[v][15:8]);
         @(negedge clk);
         chk($sformatf("R5-vector %0d next cycle", v), rd_data, VEC[v][7:0]);
      end

      // R3 the fast strobe drives the prescaler reset for one cycle
      reg_write(8'h01);
      chk("R3 sync_psr_rst high", sync_psr_rst, 1'b1);
      @(negedge clk);
      chk("R3 sync_psr_rst low", sync_psr_rst, 1'b0);

      // R6 held requests freeze both CPU-clocked counters
      reg_write(8'h83);
      idle(6);
      chk("R6 fast count held", sync_div_cnt, '0);
      chk("R6 second count held", async_div_cnt, '0);
      // R7 release restarts both on the same edge
      reg_write(8'h00);
      chk("R7 release reads zero", rd_data, 8'h00);
      idle(4);
      chk("R7 fast count", sync_div_cnt, 4);
      chk("R7 lockstep", async_div_cnt, 4);

      // R8 asynchronous request waits for the slow-domain round trip
      async_mode = 1'b1;
      idle(30);
      reg_write(8'h02);
      chk("R8 pending after write", rd_data[1], 1'b1);
      idle(2);
      chk("R8 pending two cycles on", rd_data[1], 1'b1);
      waited = 0;
      while (rd_data[1] && waited < 20) begin
         @(negedge clk);
         waited++;
      end
      chk("R8 cleared by acknowledge", rd_data[1], 1'b0);

      // R9 hold mode outranks the acknowledge; R10 slow counter frozen
      idle(30);
      reg_write(8'h82);
      idle(40);
      chk("R9 still held", rd_data, 8'h82);
      chk("R10 slow reset asserted", async_psr_rst, 1'b1);
      chk("R10 slow count held", async_div_cnt, '0);
      reg_write(8'h00);
      chk("R7 async release", rd_data, 8'h00);
      idle(40);
      chk("R10 slow reset released", async_psr_rst, 1'b0);

      done = 1'b1;
      finish_run();
   end
endmodule